// File: doc/BRIEF.md
# Delta-Panel Video Timing Generator

This block drives a small colour panel whose sub-pixels sit in a delta arrangement. It runs on the dot clock. A dot counter and a line counter produce active-low horizontal and vertical sync. A data-valid window frames the visible dots of each visible line. During that window a 6-bit data bus carries one colour component per dot.

The pixel source offers a full red/green/blue pixel whenever the block raises a request, and the block stores it. It then sends the three components over the next three dots. On odd visible lines the components go out red, green, blue. On even visible lines the start shifts by one position, so they go out green, blue, red. This matches the half-pixel offset between neighbouring rows of a delta panel. The panel samples on the rising dot-clock edge, so every register in the block updates on the falling edge.

Line length, field length, sync widths, window positions and the data width are parameters. The defaults describe a 360-dot line, a 262-line field and a 280 x 220 visible area.

Top module: `delta_timing_gen`

## Requirements
- R1: A line lasts LINE_DOTS dot clocks (default 360). The dot count runs 0 to LINE_DOTS-1 and each line begins at dot 0.
- R2: A field lasts FIELD_LINES lines (default 262). The line count runs 0 to FIELD_LINES-1 and wraps to line 0.
- R3: `hsync_n` goes low at dot 0 of each line and stays low for HS_WIDTH dots (default 1).
- R4: `vsync_n` goes low at dot 0 of line 0 and stays low for VS_WIDTH whole lines (default 3).
- R5: On a visible line, `data_valid` is high for dots H_START to H_START+H_ACTIVE-1 (default 57 to 336). The first valid dot is therefore the 57th dot clock after the hsync falling edge, and the window is 280 dots wide.
- R6: Visible lines are lines V_START to V_START+V_ACTIVE-1 (default 25 to 244). `data_valid` stays low on every other line.
- R7: Visible lines are numbered from 1 at line V_START. On an odd visible line, valid dot d (counted from 1) carries component (d-1) mod 3 of the stored pixel, where 0 is red, 1 is green and 2 is blue. The order is R,G,B,R,...
- R8: On an even visible line, valid dot d carries component d mod 3 under the same encoding. The order is G,B,R,G,...
- R9: `data_out` is zero whenever `data_valid` is low.
- R10: `pix_req` is high for one dot on visible lines only. It rises at dot H_START-1 and then every third dot, but never on the last valid dot. The pixel on `pix_r`/`pix_g`/`pix_b` while `pix_req` is high is the pixel whose components fill the next three valid dots.
- R11: All outputs change only on the falling edge of `clk_dot`.
- R12: While `rst_n` is low at a falling edge, both counters go to zero. Both syncs are driven high, and `data_valid`, `pix_req` and `data_out` are driven to zero. After release, the first hsync pulse comes at the first line wrap and the first vsync pulse comes at the first field wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dot | input | 1 | Dot clock; all registers update on its falling edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_r | input | PIX_W | Red component of the offered pixel |
| pix_g | input | PIX_W | Green component of the offered pixel |
| pix_b | input | PIX_W | Blue component of the offered pixel |
| pix_req | output | 1 | Pixel request, one dot ahead of each pixel's first component |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| data_valid | output | 1 | High on visible dots of visible lines |
| data_out | output | PIX_W | Colour component for the current dot |

## Verification
The bench builds the block with a 40-dot line, a 16-line field, a 2-dot hsync, a 3-line vsync, a window of dots 7 to 26 and visible lines 4 to 11. At these sizes two whole fields, a mid-line reset and a further field fit in a few thousand cycles. The 20-dot window ends on a partial pixel, so the last-dot request suppression and the two leftover components are both exercised. The 8 visible lines give both parities several times, and the final visible line is an even one. A 2-dot hsync checks the pulse end condition beyond a single dot.

// File: rtl/dtg_pkg.sv
// dtg_pkg: shared colour encoding and colour-order helper for the delta timing generator.
// Assumes a phase value of 0..2 and a one-bit line-parity shift.
package dtg_pkg;

    typedef enum logic [1:0] {
        COL_RED   = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2
    } colour_e;

    // Rotate the pixel phase by the line-parity shift, modulo three.
    function automatic colour_e colour_at(input logic [1:0] phase, input logic shift);
        logic [1:0] s;
        s = phase + {1'b0, shift};
        if (s == 2'd3) s = 2'd0;
        return colour_e'(s);
    endfunction

endpackage

// File: rtl/dtg_hcounter.sv
// dtg_hcounter: dot counter for one line. It produces hsync, the horizontal
// window, the pixel phase inside the window and the request slot.
// Assumes H_START >= 1, HS_WIDTH >= 1 and H_START+H_ACTIVE <= LINE_DOTS.
// All state updates on the falling clock edge.
module dtg_hcounter #(
    parameter int LINE_DOTS = 360,
    parameter int HS_WIDTH  = 1,
    parameter int H_START   = 57,
    parameter int H_ACTIVE  = 280
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       line_end,
    output logic       hsync_n,
    output logic       hwin,
    output logic [1:0] phase,
    output logic       req_slot
);

    localparam int HW = $clog2(LINE_DOTS);
    localparam logic [HW-1:0] DOT_LAST  = HW'(LINE_DOTS - 1);
    localparam logic [HW-1:0] WIN_FIRST = HW'(H_START);
    localparam logic [HW-1:0] WIN_LAST  = HW'(H_START + H_ACTIVE - 1);
    localparam logic [HW-1:0] PRE_FIRST = HW'(H_START - 1);
    localparam logic [HW-1:0] SYNC_LAST = HW'(HS_WIDTH - 1);

    logic [HW-1:0] cnt_q;
    logic          hs_q;
    logic [1:0]    ph_q;

    assign line_end = (cnt_q == DOT_LAST);
    assign hwin     = (cnt_q >= WIN_FIRST) && (cnt_q <= WIN_LAST);
    assign hsync_n  = hs_q;
    assign phase    = ph_q;
    assign req_slot = (cnt_q == PRE_FIRST) ||
                      (hwin && (ph_q == 2'd2) && (cnt_q != WIN_LAST));

    // Dot counter: wraps at the end of each line.
    always_ff @(negedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (line_end) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // Hsync: starts only at a line wrap, so no runt pulse follows reset.
    always_ff @(negedge clk) begin
        if (!rst_n)                           hs_q <= 1'b1;
        else if (line_end)                    hs_q <= 1'b0;
        else if (!hs_q && cnt_q == SYNC_LAST) hs_q <= 1'b1;
    end

    // Pixel phase: counts 0,1,2 through the window, held at 0 outside it.
    always_ff @(negedge clk) begin
        if (!rst_n || !hwin)  ph_q <= 2'd0;
        else if (ph_q == 2'd2) ph_q <= 2'd0;
        else                   ph_q <= ph_q + 2'd1;
    end

    assert_hsync_at_dot0_R3: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(hs_q) |-> (cnt_q == '0));
    assert_hsync_width_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (!hs_q && cnt_q == SYNC_LAST) |=> hs_q);
    assert_line_wrap_R1: assert property (@(negedge clk) disable iff (!rst_n)
        line_end |=> (cnt_q == '0));
    assert_phase_legal_R7: assert property (@(negedge clk) disable iff (!rst_n)
        ph_q != 2'd3);

endmodule

// File: rtl/dtg_vcounter.sv
// dtg_vcounter: line counter for one field. It produces vsync, the vertical
// window and the visible-line parity.
// Assumes VS_WIDTH <= V_START and V_START+V_ACTIVE <= FIELD_LINES.
// Advances only at the line wrap given by the dot counter.
module dtg_vcounter #(
    parameter int FIELD_LINES = 262,
    parameter int VS_WIDTH    = 3,
    parameter int V_START     = 25,
    parameter int V_ACTIVE    = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_end,
    output logic vsync_n,
    output logic vwin,
    output logic even_line
);

    localparam int VW = $clog2(FIELD_LINES);
    localparam logic [VW-1:0] LINE_LAST  = VW'(FIELD_LINES - 1);
    localparam logic [VW-1:0] VIS_FIRST  = VW'(V_START);
    localparam logic [VW-1:0] VIS_LAST   = VW'(V_START + V_ACTIVE - 1);
    localparam logic [VW-1:0] VSYNC_LAST = VW'(VS_WIDTH - 1);
    localparam logic          VIS_PAR    = 1'(V_START % 2);

    logic [VW-1:0] vcnt_q;
    logic          vs_q;
    logic          field_end;

    assign field_end = line_end && (vcnt_q == LINE_LAST);
    assign vwin      = (vcnt_q >= VIS_FIRST) && (vcnt_q <= VIS_LAST);
    assign even_line = vcnt_q[0] ^ VIS_PAR;
    assign vsync_n   = vs_q;

    // Line counter: steps at each line end and wraps at the field end.
    always_ff @(negedge clk) begin
        if (!rst_n)         vcnt_q <= '0;
        else if (field_end) vcnt_q <= '0;
        else if (line_end)  vcnt_q <= vcnt_q + 1'b1;
    end

    // Vsync: starts only at a field wrap and ends after VS_WIDTH whole lines.
    always_ff @(negedge clk) begin
        if (!rst_n)                                       vs_q <= 1'b1;
        else if (field_end)                               vs_q <= 1'b0;
        else if (!vs_q && line_end && vcnt_q == VSYNC_LAST) vs_q <= 1'b1;
    end

    assert_vsync_at_line0_R4: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(vs_q) |-> (vcnt_q == '0));
    assert_line_range_R2: assert property (@(negedge clk) disable iff (!rst_n)
        vcnt_q <= LINE_LAST);
    assert_visible_clear_of_vsync_R6: assert property (@(negedge clk) disable iff (!rst_n)
        vwin |-> vs_q);

endmodule

// File: rtl/dtg_colour_mux.sv
// dtg_colour_mux: stores the offered pixel at each request and drives one
// component per valid dot. The choice follows the pixel phase, rotated by
// the line parity. Assumes a request comes one dot before each pixel's first dot.
module dtg_colour_mux
    import dtg_pkg::*;
#(
    parameter int PIX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    input  logic             dvalid,
    input  logic [1:0]       phase,
    input  logic             even_line,
    output logic [PIX_W-1:0] dout
);

    logic [PIX_W-1:0] r_q, g_q, b_q;
    colour_e          sel;

    assign sel = colour_at(phase, even_line);

    // Pixel store: loads the offered pixel on a request.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            g_q <= '0;
            b_q <= '0;
        end else if (take) begin
            r_q <= in_r;
            g_q <= in_g;
            b_q <= in_b;
        end
    end

    // Component select: zero outside the window.
    always_comb begin
        if (!dvalid) dout = '0;
        else begin
            case (sel)
                COL_RED:   dout = r_q;
                COL_GREEN: dout = g_q;
                default:   dout = b_q;
            endcase
        end
    end

endmodule

// File: rtl/delta_timing_gen.sv
// delta_timing_gen: sync, data-valid and colour-component generator for a
// delta-arranged panel. Every register updates on the falling edge of the
// dot clock, so the panel can sample on the rising edge.
// Assumes parameter values consistent with the sub-module assumptions.
module delta_timing_gen #(
    parameter int LINE_DOTS   = 360,
    parameter int HS_WIDTH    = 1,
    parameter int H_START     = 57,
    parameter int H_ACTIVE    = 280,
    parameter int FIELD_LINES = 262,
    parameter int VS_WIDTH    = 3,
    parameter int V_START     = 25,
    parameter int V_ACTIVE    = 220,
    parameter int PIX_W       = 6
) (
    input  logic             clk_dot,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    output logic             pix_req,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             data_valid,
    output logic [PIX_W-1:0] data_out
);

    logic       line_end;
    logic       hwin;
    logic [1:0] phase;
    logic       req_slot;
    logic       vwin;
    logic       even_line;

    dtg_hcounter #(
        .LINE_DOTS (LINE_DOTS),
        .HS_WIDTH  (HS_WIDTH),
        .H_START   (H_START),
        .H_ACTIVE  (H_ACTIVE)
    ) u_hcount (
        .clk      (clk_dot),
        .rst_n    (rst_n),
        .line_end (line_end),
        .hsync_n  (hsync_n),
        .hwin     (hwin),
        .phase    (phase),
        .req_slot (req_slot)
    );

    dtg_vcounter #(
        .FIELD_LINES (FIELD_LINES),
        .VS_WIDTH    (VS_WIDTH),
        .V_START     (V_START),
        .V_ACTIVE    (V_ACTIVE)
    ) u_vcount (
        .clk       (clk_dot),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .vsync_n   (vsync_n),
        .vwin      (vwin),
        .even_line (even_line)
    );

    assign data_valid = hwin && vwin;
    assign pix_req    = req_slot && vwin;

    dtg_colour_mux #(
        .PIX_W (PIX_W)
    ) u_mux (
        .clk       (clk_dot),
        .rst_n     (rst_n),
        .take      (pix_req),
        .in_r      (pix_r),
        .in_g      (pix_g),
        .in_b      (pix_b),
        .dvalid    (data_valid),
        .phase     (phase),
        .even_line (even_line),
        .dout      (data_out)
    );

    assert_req_spaced_R10: assert property (@(negedge clk_dot) disable iff (!rst_n)
        pix_req |=> !pix_req);
    assert_req_leads_window_R10: assert property (@(negedge clk_dot) disable iff (!rst_n)
        $rose(data_valid) |-> $past(pix_req));
    assert_quiet_outside_R9: assert property (@(negedge clk_dot) disable iff (!rst_n)
        (!data_valid && !$past(data_valid)) |-> (data_out == '0));

endmodule

// File: tb/test_delta_timing_gen.sv
`timescale 1ns/1ps
module test_delta_timing_gen;

    localparam int L   = 40;
    localparam int F   = 16;
    localparam int HSW = 2;
    localparam int HST = 7;
    localparam int HA  = 20;
    localparam int VSW = 3;
    localparam int VST = 4;
    localparam int VA  = 8;
    localparam int PW  = 6;
    localparam int NPROBE = 14;

    // Probe table: line, dot, hsync_n, vsync_n, data_valid, pix_req, colour (0 R, 1 G, 2 B, 3 none)
    localparam int PROBE [NPROBE][7] = '{
        '{ 0,  0, 0, 0, 0, 0, 3},
        '{ 0,  2, 1, 0, 0, 0, 3},
        '{ 2,  1, 0, 0, 0, 0, 3},
        '{ 3,  0, 0, 1, 0, 0, 3},
        '{ 4,  6, 1, 1, 0, 1, 3},
        '{ 4,  7, 1, 1, 1, 0, 0},
        '{ 4,  9, 1, 1, 1, 1, 2},
        '{ 4, 25, 1, 1, 1, 0, 0},
        '{ 4, 26, 1, 1, 1, 0, 1},
        '{ 4, 27, 1, 1, 0, 0, 3},
        '{ 5,  7, 1, 1, 1, 0, 1},
        '{ 5,  9, 1, 1, 1, 1, 0},
        '{11,  7, 1, 1, 1, 0, 1},
        '{12,  7, 1, 1, 0, 0, 3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pr = '0, pg = '0, pb = '0;
    logic          pix_req, hsync_n, vsync_n, data_valid;
    logic [PW-1:0] data_out;

    int n_vec = 0;
    int n_bad = 0;
    int k = 0;
    int pi = 0;

    always #2 clk = ~clk;

    delta_timing_gen #(
        .LINE_DOTS (L), .HS_WIDTH (HSW), .H_START (HST), .H_ACTIVE (HA),
        .FIELD_LINES (F), .VS_WIDTH (VSW), .V_START (VST), .V_ACTIVE (VA),
        .PIX_W (PW)
    ) i_delta_timing_gen (
        .clk_dot (clk), .rst_n (rst_n),
        .pix_r (pr), .pix_g (pg), .pix_b (pb),
        .pix_req (pix_req), .hsync_n (hsync_n), .vsync_n (vsync_n),
        .data_valid (data_valid), .data_out (data_out)
    );

    function automatic string probe_tag(input int i);
        case (i)
            0: return "R2";   1: return "R3";   2: return "R4";   3: return "R1";
            4: return "R10";  5: return "R7";   6: return "R7";   7: return "R7";
            8: return "R5";   9: return "R9";   10: return "R8";  11: return "R8";
            12: return "R8";  default: return "R6";
        endcase
    endfunction

    function automatic int pval(input int line, input int p, input int ch);
        return (line * 11 + p * 5 + ch * 21) % 64;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (dot step %0d)", tag, act, exp, k);
        end
    endtask

    // Walk ncyc dots, comparing every output against the requirement model.
    task automatic walk(input int ncyc, input bit probe);
        for (int n = 0; n < ncyc; n++) begin
            int dot, line, d, p, ev, c, exp_dout;
            bit vact, dv, req, hs, vs;
            logic [PW+3:0] snap;
            @(posedge clk);
            k++;
            dot  = k % L;
            line = (k / L) % F;
            vact = (line >= VST) && (line < VST + VA);
            dv   = vact && (dot >= HST) && (dot < HST + HA);
            req  = vact && (dot >= HST - 1) && (dot < HST + HA - 1) && ((dot - HST + 1) % 3 == 0);
            hs   = !((k >= L) && (dot < HSW));
            vs   = !((k >= L * F) && (line < VSW));
            ev   = ((line - VST) % 2 + 2) % 2;
            d    = dot - HST + 1;
            p    = (d > 0) ? (d - 1) / 3 : 0;
            c    = (d > 0) ? (((d - 1) % 3) + ev) % 3 : 0;
            exp_dout = dv ? pval(line, p, c) : 0;
            chk("R3", int'(hsync_n), int'(hs));
            chk("R4", int'(vsync_n), int'(vs));
            chk("R5", int'(data_valid), int'(dv));
            chk("R10", int'(pix_req), int'(req));
            chk(dv ? (ev == 1 ? "R8" : "R7") : "R9", int'(data_out), exp_dout);
            if (probe && pi < NPROBE && k >= L * F && k < 2 * L * F &&
                line == PROBE[pi][0] && dot == PROBE[pi][1]) begin
                chk(probe_tag(pi), int'(hsync_n), PROBE[pi][2]);
                chk(probe_tag(pi), int'(vsync_n), PROBE[pi][3]);
                chk(probe_tag(pi), int'(data_valid), PROBE[pi][4]);
                chk(probe_tag(pi), int'(pix_req), PROBE[pi][5]);
                chk(probe_tag(pi), int'(data_out),
                    (PROBE[pi][6] == 3) ? 0 : pval(line, p, PROBE[pi][6]));
                pi++;
            end
            snap = {hsync_n, vsync_n, data_valid, pix_req, data_out};
            #1;
            chk("R11", int'({hsync_n, vsync_n, data_valid, pix_req, data_out}), int'(snap));
            if (pix_req) begin
                int rp;
                rp = (dot - HST + 1) / 3;
                pr = PW'(pval(line, rp, 0));
                pg = PW'(pval(line, rp, 1));
                pb = PW'(pval(line, rp, 2));
            end
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, int'(hsync_n), 1);
        chk(tag, int'(vsync_n), 1);
        chk(tag, int'(data_valid), 0);
        chk(tag, int'(pix_req), 0);
        chk(tag, int'(data_out), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        chk_idle("R12");                 // reset state
        rst_n = 1'b1;
        k = 0;
        walk(2 * L * F, 1'b1);           // two fields with probe table
        chk("R1", pi, NPROBE);           // every probe row was reached
        walk(5 * L + 10, 1'b0);          // stop inside a visible line
        rst_n = 1'b0;                    // R12: reset in mid-line
        @(posedge clk);
        chk_idle("R12");
        repeat (2) @(posedge clk);
        chk_idle("R12");
        rst_n = 1'b1;
        k = 0;
        walk(L * F + 3 * L, 1'b0);       // restart: no runt sync, full field again
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule